// File: doc/BRIEF.md
# Triplicated Scrubbed Instruction ROM

This block is a radiation-tolerant program store for a small processor core. The program is held three times, in three dual-port memories. The processor never writes to it: the fetch side only reads. On every fetch the three copies are read side by side, and a bitwise two-out-of-three vote forms the instruction word. Because of the vote, an upset in any single copy is masked at the output.

Masking alone does not keep the store healthy. Upsets in different copies of the same word would build up until the vote fails. A background scrubber prevents this through the second port of each memory. It steps through the address space, spending one cycle reading all three copies and one cycle writing the voted word back into each copy. The scrub address and phase are held in three counter instances. These vote among themselves, and each instance drives the write enable of its own copy only. A scrub write never lands on the address that the fetch port is reading in that cycle: the fetch wins and the write waits. A preload port writes the initial program into all three copies. A flip input, meant only for test benches, inverts a single stored bit in one chosen copy.

Top module: `tmr_irom`

## Requirements
- R1: `instr_o` presents, one clock edge after `fetch_addr` is sampled, the word stored at that address when all three copies agree.
- R2: A cycle with `load_we` high writes `load_data` at `load_addr` into all three copies, and later fetches of that address return it.
- R3: Each output bit is the majority of the three copies, so inverting any single bit of any single copy leaves `instr_o` unchanged.
- R4: The scrub address moves only by +1 modulo the depth: it wraps from the last address to 0, and words at both ends of the range are repaired.
- R5: Each address takes at least one read cycle and one write-back cycle, so the scrubber advances at most once every two clocks.
- R6: No copy is scrub-written at the address that `fetch_addr` carries in the same cycle; that write is held back, and fetches stay correct while scrubbing runs.
- R7: With `scrub_en` high, a single-copy upset is overwritten with the voted word within one pass of the address space.
- R8: With `scrub_en` low no scrub write happens, so upsets persist and two upsets in one bit of one word show up at `instr_o`.
- R9: While `load_we` is high the scrubber is suspended and goes back to its read cycle, so a word it read before the load is never written back over the loaded one.
- R10: The three scrub counter instances hold identical state, each copy's write enable comes from its own instance, and each copy in turn gets repaired.
- R11: While `rst` is high, `instr_o` is 0 and the scrubber returns to address 0 in its read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory and scrubber clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | ADDR_W | Processor instruction address |
| instr_o | output | DATA_W | Voted instruction word, registered |
| scrub_en | input | 1 | Runs the background scrubber while high |
| load_we | input | 1 | Preload write strobe for all three copies |
| load_addr | input | ADDR_W | Preload address |
| load_data | input | DATA_W | Preload word |
| flip_en | input | 1 | Test hook: invert one stored bit |
| flip_copy | input | 2 | Copy selected by the test hook (0 to 2) |
| flip_addr | input | ADDR_W | Address hit by the test hook |
| flip_bit | input | $clog2(DATA_W) | Bit index hit by the test hook |

## Verification
Random fetch sequences over a randomly preloaded program show that the output tracks stored contents. With the scrubber running, a fetch address drawn anew every cycle sometimes lands on the scrub target, which exercises the deferred write. Directed flips at bit 0 and the top bit of each copy separate a true majority from a copy-select. A second flip in another copy at the same bit is the probe for whether a word was repaired. It corrupts the output when the first upset is still present, and not when the first upset has been scrubbed away. This probe separates a running scrubber from a disabled one, a half-rate walk from a faster one, and a wrap at the end of the range from a stall. A preload placed on a word while that word's scrub write is pending separates suspension from a stale write-back.

// File: rtl/tmr_irom_pkg.sv
`timescale 1ns/1ps
package tmr_irom_pkg;

    // Two-step scrub cycle for one address
    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } scrub_phase_e;

    localparam int unsigned N_COPIES = 3;

    // Two-out-of-three majority of single bits
    function automatic logic maj_bit(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/trom_vote.sv
`timescale 1ns/1ps
module trom_vote
    import tmr_irom_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = maj_bit(a[i], b[i], c[i]);
    end
endmodule

// File: rtl/trom_bank.sv
`timescale 1ns/1ps
module trom_bank #(
    parameter int AW = 6,
    parameter int DW = 18,
    parameter int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    // fetch port: read only
    input  logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] fetch_q,
    // scrub port
    input  logic [AW-1:0] scr_addr,
    input  logic          scr_rd,
    output logic [DW-1:0] scr_q,
    input  logic          scr_we,
    input  logic [DW-1:0] scr_wdata,
    // preload
    input  logic          load_we,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    // test hook
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    input  logic [BW-1:0] flip_bit
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= '0;
            scr_q   <= '0;
        end else begin
            fetch_q <= mem[fetch_addr];
            if (scr_rd) begin
                scr_q <= mem[scr_addr];
            end
        end
    end

    // Preload wins over the hook, the hook wins over scrubbing
    always_ff @(posedge clk) begin
        if (load_we) begin
            mem[load_addr] <= load_data;
        end else if (flip_en) begin
            mem[flip_addr][flip_bit] <= ~mem[flip_addr][flip_bit];
        end else if (scr_we) begin
            mem[scr_addr] <= scr_wdata;
        end
    end
endmodule

// File: rtl/trom_scrub_ctr.sv
`timescale 1ns/1ps
module trom_scrub_ctr
    import tmr_irom_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] fetch_addr,
    input  logic [AW-1:0] vote_addr,
    input  logic          vote_ph,
    output logic [AW-1:0] addr_o,
    output logic          ph_o,
    output logic          rd_o,
    output logic          we_o
);
    scrub_phase_e  ph_q;
    scrub_phase_e  ph_v;
    logic [AW-1:0] addr_q;
    logic          clash_v;

    assign ph_v    = scrub_phase_e'(vote_ph);
    assign clash_v = (vote_addr == fetch_addr);

    // Outputs come from this instance's own state only
    assign addr_o = addr_q;
    assign ph_o   = ph_q;
    assign rd_o   = go && (ph_q == PH_READ);
    assign we_o   = go && (ph_q == PH_WRITE) && (addr_q != fetch_addr);

    // Next state is taken from the voted state of all three instances
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ph_q   <= PH_READ;
        end else if (!go) begin
            addr_q <= vote_addr;
            ph_q   <= PH_READ;
        end else if (ph_v == PH_READ) begin
            addr_q <= vote_addr;
            ph_q   <= PH_WRITE;
        end else if (clash_v) begin
            addr_q <= vote_addr;
            ph_q   <= PH_WRITE;
        end else begin
            addr_q <= vote_addr + AW'(1);
            ph_q   <= PH_READ;
        end
    end
endmodule

// File: rtl/tmr_irom.sv
`timescale 1ns/1ps
module tmr_irom
    import tmr_irom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] instr_o,
    input  logic              scrub_en,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              flip_en,
    input  logic [1:0]        flip_copy,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [BIT_W-1:0]  flip_bit
);
    logic [N_COPIES-1:0][DATA_W-1:0] fetch_q;
    logic [N_COPIES-1:0][DATA_W-1:0] scr_q;
    logic [N_COPIES-1:0][ADDR_W-1:0] ctr_addr;
    logic [N_COPIES-1:0]             ctr_ph;
    logic [N_COPIES-1:0]             ctr_rd;
    logic [N_COPIES-1:0]             scrub_we;
    logic [ADDR_W-1:0]               vote_addr;
    logic                            vote_ph;
    logic [DATA_W-1:0]               scrub_word;
    logic                            go;

    assign go = scrub_en && !load_we;

    trom_vote #(.W(DATA_W)) u_vote_fetch (
        .a(fetch_q[0]), .b(fetch_q[1]), .c(fetch_q[2]), .y(instr_o)
    );
    trom_vote #(.W(DATA_W)) u_vote_scrub (
        .a(scr_q[0]), .b(scr_q[1]), .c(scr_q[2]), .y(scrub_word)
    );
    trom_vote #(.W(ADDR_W)) u_vote_addr (
        .a(ctr_addr[0]), .b(ctr_addr[1]), .c(ctr_addr[2]), .y(vote_addr)
    );
    trom_vote #(.W(1)) u_vote_ph (
        .a(ctr_ph[0]), .b(ctr_ph[1]), .c(ctr_ph[2]), .y(vote_ph)
    );

    for (genvar k = 0; k < N_COPIES; k++) begin : g_copy
        logic hit;
        assign hit = flip_en && (flip_copy == 2'(k));

        trom_scrub_ctr #(.AW(ADDR_W)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .go        (go),
            .fetch_addr(fetch_addr),
            .vote_addr (vote_addr),
            .vote_ph   (vote_ph),
            .addr_o    (ctr_addr[k]),
            .ph_o      (ctr_ph[k]),
            .rd_o      (ctr_rd[k]),
            .we_o      (scrub_we[k])
        );

        trom_bank #(.AW(ADDR_W), .DW(DATA_W), .BW(BIT_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .fetch_addr(fetch_addr),
            .fetch_q   (fetch_q[k]),
            .scr_addr  (ctr_addr[k]),
            .scr_rd    (ctr_rd[k]),
            .scr_q     (scr_q[k]),
            .scr_we    (scrub_we[k]),
            .scr_wdata (scrub_word),
            .load_we   (load_we),
            .load_addr (load_addr),
            .load_data (load_data),
            .flip_en   (hit),
            .flip_addr (flip_addr),
            .flip_bit  (flip_bit)
        );
    end
endmodule

// File: rtl/tmr_irom_chk.sv
`timescale 1ns/1ps
module tmr_irom_chk #(
    parameter int AW = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               scrub_en,
    input logic               load_we,
    input logic [AW-1:0]      fetch_addr,
    input logic [2:0][AW-1:0] ctr_addr,
    input logic [2:0]         ctr_ph,
    input logic [2:0]         scrub_we
);
    p_ctr_agree_r10: assert property (@(posedge clk) disable iff (rst)
        (ctr_addr[0] == ctr_addr[1]) && (ctr_addr[1] == ctr_addr[2]) &&
        (ctr_ph[0] == ctr_ph[1]) && (ctr_ph[1] == ctr_ph[2]));

    p_we_together_r10: assert property (@(posedge clk) disable iff (rst)
        (scrub_we == 3'b000) || (scrub_we == 3'b111));

    p_no_conflict_r6: assert property (@(posedge clk) disable iff (rst)
        (|scrub_we) |-> (ctr_addr[0] != fetch_addr));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (ctr_addr[0] != $past(ctr_addr[0])) |->
            (ctr_addr[0] == $past(ctr_addr[0]) + AW'(1)));

    p_half_rate_r5: assert property (@(posedge clk) disable iff (rst)
        (ctr_addr[0] != $past(ctr_addr[0])) |=> $stable(ctr_addr[0]));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !scrub_en |-> (scrub_we == 3'b000));

    p_load_hold_r9: assert property (@(posedge clk) disable iff (rst)
        load_we |=> (ctr_ph == 3'b000));
endmodule

bind tmr_irom tmr_irom_chk #(.AW(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .scrub_en  (scrub_en),
    .load_we   (load_we),
    .fetch_addr(fetch_addr),
    .ctr_addr  (ctr_addr),
    .ctr_ph    (ctr_ph),
    .scrub_we  (scrub_we)
);

// File: tb/tmr_irom_tb_top.sv
`timescale 1ns/1ps
module tmr_irom_tb_top;
    localparam int AW    = 6;
    localparam int DW    = 18;
    localparam int BW    = $clog2(DW);
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_addr = '0;
    logic [DW-1:0] instr_o;
    logic          scrub_en = 1'b0;
    logic          load_we = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic          flip_en = 1'b0;
    logic [1:0]    flip_copy = 2'd3;
    logic [AW-1:0] flip_addr = '0;
    logic [BW-1:0] flip_bit = '0;

    logic [DW-1:0] exp_mem [DEPTH];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_irom #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .instr_o(instr_o),
        .scrub_en(scrub_en), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .flip_en(flip_en), .flip_copy(flip_copy),
        .flip_addr(flip_addr), .flip_bit(flip_bit)
    );

    function automatic logic [DW-1:0] bitmask(input int b);
        return DW'(1) << b;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic fetch_chk(input int a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk); fetch_addr = AW'(a);
        @(negedge clk); chk(tag, instr_o, exp);
    endtask

    task automatic flip(input int k, input int a, input int b);
        @(negedge clk);
        flip_en = 1'b1; flip_copy = 2'(k); flip_addr = AW'(a); flip_bit = BW'(b);
        @(negedge clk);
        flip_en = 1'b0; flip_copy = 2'd3;
    endtask

    task automatic load(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        load_we = 1'b1; load_addr = AW'(a); load_data = d; exp_mem[a] = d;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; scrub_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 instr_o during reset", instr_o, '0);
        rst = 1'b0;
    endtask

    // scrubber on, fresh random fetch address every cycle, each result checked
    task automatic run_scrub(input int n);
        int prev;
        @(negedge clk);
        scrub_en = 1'b1;
        prev = int'($urandom_range(DEPTH - 1));
        fetch_addr = AW'(prev);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R6 fetch while scrubbing", instr_o, exp_mem[prev]);
            prev = int'($urandom_range(DEPTH - 1));
            fetch_addr = AW'(prev);
        end
        scrub_en = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int a, b, a2;
        logic [DW-1:0] w;
        void'($urandom(32'h5EED_0042));

        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 instr_o during reset", instr_o, '0);
        rst = 1'b0;

        // R2: preload a random program
        for (int i = 0; i < DEPTH; i++) load(i, DW'($urandom));

        // R1: random fetches
        for (int i = 0; i < 40; i++) begin
            a = int'($urandom_range(DEPTH - 1));
            fetch_chk(a, exp_mem[a], "R1 random fetch");
        end
        fetch_chk(0, exp_mem[0], "R2 first word");
        fetch_chk(DEPTH - 1, exp_mem[DEPTH - 1], "R2 last word");

        // R3: single-copy upsets masked, edge bits and a random bit
        for (int k = 0; k < 3; k++) begin
            a = int'($urandom_range(DEPTH - 1));
            b = int'($urandom_range(DW - 1));
            flip(k, a, 0);      fetch_chk(a, exp_mem[a], "R3 bit 0 upset");      flip(k, a, 0);
            flip(k, a, DW - 1); fetch_chk(a, exp_mem[a], "R3 top bit upset");    flip(k, a, DW - 1);
            flip(k, a, b);      fetch_chk(a, exp_mem[a], "R3 random bit upset"); flip(k, a, b);
        end

        // R8: with scrub off, double upsets persist and reach the output
        a = 17; b = 5;
        flip(0, a, b); flip(1, a, b);
        repeat (200) @(negedge clk);
        fetch_chk(a, exp_mem[a] ^ bitmask(b), "R8 upsets persist without scrub");
        flip(0, a, b); flip(1, a, b);
        fetch_chk(a, exp_mem[a], "R8 restore");

        // R5: half-rate walk from address 0 after reset
        do_reset();
        fetch_addr = AW'(DEPTH - 1);
        flip(1, 10, 3);
        @(negedge clk); scrub_en = 1'b1;
        repeat (16) @(posedge clk);
        @(negedge clk); scrub_en = 1'b0;
        flip(2, 10, 3);
        fetch_chk(10, exp_mem[10] ^ bitmask(3), "R5 address 10 not reached in 16 cycles");
        flip(2, 10, 3);
        fetch_addr = AW'(DEPTH - 1);
        @(negedge clk); scrub_en = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk); scrub_en = 1'b0;
        flip(2, 10, 3);
        fetch_chk(10, exp_mem[10], "R5 address 10 repaired after 8 more cycles");
        flip(2, 10, 3);

        // R7/R10: each copy repaired in turn
        for (int k = 0; k < 3; k++) begin
            a = int'($urandom_range(DEPTH - 1));
            b = int'($urandom_range(DW - 1));
            flip(k, a, b);
            run_scrub(300);
            flip((k + 1) % 3, a, b);
            fetch_chk(a, exp_mem[a], "R7 R10 copy repaired by scrub");
            flip((k + 1) % 3, a, b);
        end

        // R4: wrap, repair at both ends of the range
        do_reset();
        run_scrub(20);
        flip(2, 0, 1); flip(2, DEPTH - 1, DW - 1);
        run_scrub(200);
        flip(0, 0, 1);
        fetch_chk(0, exp_mem[0], "R4 address 0 repaired after wrap");
        flip(0, 0, 1);
        flip(1, DEPTH - 1, DW - 1);
        fetch_chk(DEPTH - 1, exp_mem[DEPTH - 1], "R4 last address repaired");
        flip(1, DEPTH - 1, DW - 1);

        // R9: preload over a word with a held-back scrub write
        do_reset();
        fetch_addr = '0;
        @(negedge clk); scrub_en = 1'b1;
        @(negedge clk);
        w = ~exp_mem[0];
        load_we = 1'b1; load_addr = '0; load_data = w; exp_mem[0] = w;
        @(negedge clk);
        load_we = 1'b0; fetch_addr = AW'(5);
        run_scrub(300);
        fetch_chk(0, w, "R9 load not overwritten by stale scrub");

        // R2/R9: random preloads mixed with scrubbing
        for (int i = 0; i < 8; i++) begin
            a2 = int'($urandom_range(DEPTH - 1));
            @(negedge clk); scrub_en = 1'b1;
            load(a2, DW'($urandom));
            run_scrub(30);
        end
        for (int i = 0; i < DEPTH; i++) fetch_chk(i, exp_mem[i], "R2 R9 full readback");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule